// File: doc/BRIEF.md
# Accumulator Processor Core with Stepped Register Transfers

This block is a small multicycle processor built around a single 16-bit accumulator. Every instruction word holds a 4-bit operation code in its top bits and a 12-bit word address below it. The core performs exactly one register transfer per clock. Operands and results move through a memory address register and a memory buffer register. The core also holds a program counter, an instruction register, an 8-bit input latch and an 8-bit output latch.

A 4K x 16 word-addressable memory sits inside the core. While reset is held, a loader port fills it with code and data. Once reset is released, execution starts at address 0. The core reads 8-bit values from an input port guarded by a valid level. It writes 8-bit values to an output port together with a one-cycle strobe. It raises a halted flag when it reaches the stop instruction.

Top module: `acc_core`

## Requirements
- R1: While reset is held, halted, out_we and out_data are 0. After reset, PC and AC are 0. Each instruction begins with three fetch steps (MAR takes PC; IR takes memory at MAR; PC increments), then one decode cycle, then its own steps. An OUTPUT at address 0 therefore pulses out_we on the 5th clock edge after reset is released.
- R2: Opcode 1 (load) copies memory[X] into AC. Opcode 2 (store) writes AC into memory[X]. X is IR bits 11:0.
- R3: Opcode 3 adds memory[X] to AC and opcode 4 subtracts it, both in 16-bit two's complement with wrap-around.
- R4: Opcode B (indirect add) reads memory[X]. It uses that word's low 12 bits as a pointer and adds memory[pointer] to AC. The top 4 bits of the pointer word are ignored.
- R5: Opcode 8 (conditional skip) tests IR bits 11:10 and adds 1 to PC when the condition holds. The codes are: 00 tests AC negative, 01 tests AC zero, 10 tests AC greater than zero, 11 never skips.
- R6: Opcode 9 loads PC with X. Opcode C loads PC with the low 12 bits of memory[X].
- R7: Opcode 0 (jump-and-store) writes the return address into memory[X] and continues at X+1. It leaves X+1 in AC.
- R8: Opcode A sets AC to zero.
- R9: Opcode 5 waits while in_valid is low. When in_valid is high it latches in_data and places it zero-extended into AC.
- R10: Opcode 6 copies AC bits 7:0 to out_data and raises out_we for exactly one cycle.
- R11: Opcode 7 raises halted. halted then stays high until reset, with no further output strobes or memory writes.
- R12: Opcodes D, E and F change nothing except the PC advance of the fetch.
- R13: The loader port writes memory only while reset is high. A loader write while the core runs is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; enables the loader |
| prog_we | input | 1 | Loader write enable, honoured only in reset |
| prog_addr | input | 12 | Loader word address |
| prog_wdata | input | 16 | Loader write data |
| in_data | input | 8 | Input port data |
| in_valid | input | 1 | Input data is available |
| out_data | output | 8 | Output latch contents |
| out_we | output | 1 | One-cycle strobe marking a new output value |
| halted | output | 1 | Core has stopped |

## Verification
On every cycle, the assertions check the following. The fetch sequence runs in its fixed order, with MAR holding PC when the instruction is read and PC advancing by one. IR changes only in its fetch step. The input wait holds while valid is low. The output strobe never lasts two cycles. After halt, the flag stays set and the core neither strobes nor writes. The arithmetic results, the skip decision for each condition code and sign, indirect pointer masking, subroutine linkage and the dropped loader write can only be seen through the bench's programs. Those programs report their results through the output port, and the bench compares them against values it computes itself.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_JNS   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUBT  = 4'h4,
        OP_INPUT = 4'h5,
        OP_OUTPUT= 4'h6,
        OP_HALT  = 4'h7,
        OP_SKIP  = 4'h8,
        OP_JUMP  = 4'h9,
        OP_CLEAR = 4'hA,
        OP_ADDI  = 4'hB,
        OP_JUMPI = 4'hC,
        OP_NOP_D = 4'hD,
        OP_NOP_E = 4'hE,
        OP_NOP_F = 4'hF
    } opcode_e;

    typedef enum logic [4:0] {
        S_FMAR = 5'd0,
        S_FIR,
        S_FPC,
        S_DEC,
        S_MAR,
        S_RD,
        S_PTR,
        S_RD2,
        S_STM,
        S_STW,
        S_INW,
        S_EXEC,
        S_J1,
        S_J2,
        S_J3,
        S_J4,
        S_J5,
        S_J6,
        S_J7,
        S_HALT
    } state_e;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        cond,
    output logic [WORD_W-1:0] y,
    output logic              take
);
    logic neg;
    logic zero;

    assign neg  = a[WORD_W-1];
    assign zero = (a == '0);

    always_comb begin
        y = sub ? (a - b) : (a + b);
        unique case (cond)
            2'b00:   take = neg;
            2'b01:   take = zero;
            2'b10:   take = !neg && !zero;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_wdata,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_valid,
    output logic [IO_W-1:0]   out_data,
    output logic              out_we,
    output logic              halted
);
    import acc_pkg::*;

    localparam int unsigned OPC_W = WORD_W - ADDR_W;
    localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] AC_ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] mbr;
        logic [WORD_W-1:0] ac;
        logic [IO_W-1:0]   inreg;
        logic [IO_W-1:0]   outreg;
        logic              out_we;
        logic              halted;
    } regs_t;

    regs_t r_q, r_d;

    opcode_e           opc;
    logic [ADDR_W-1:0] x_addr;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] alu_y;
    logic              skip_take;
    logic              alu_sub;
    logic              core_we;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    assign opc     = opcode_e'(r_q.ir[WORD_W-1 -: OPC_W]);
    assign x_addr  = r_q.ir[ADDR_W-1:0];
    assign alu_sub = (r_q.state == S_EXEC) && (opc == OP_SUBT);
    assign core_we = (r_q.state == S_STW) || (r_q.state == S_J3);

    // loader owns the write port only while reset is held
    assign mem_we    = rst ? prog_we    : core_we;
    assign mem_waddr = rst ? prog_addr  : r_q.mar;
    assign mem_wdata = rst ? prog_wdata : r_q.mbr;

    acc_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (r_q.mar),
        .rdata (mem_rdata)
    );

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .a    (r_q.ac),
        .b    (r_q.mbr),
        .sub  (alu_sub),
        .cond (r_q.ir[ADDR_W-1 -: 2]),
        .y    (alu_y),
        .take (skip_take)
    );

    always_comb begin
        r_d        = r_q;
        r_d.out_we = 1'b0;
        unique case (r_q.state)
            S_FMAR: begin
                r_d.mar   = r_q.pc;
                r_d.state = S_FIR;
            end
            S_FIR: begin
                r_d.ir    = mem_rdata;
                r_d.state = S_FPC;
            end
            S_FPC: begin
                r_d.pc    = r_q.pc + PC_ONE;
                r_d.state = S_DEC;
            end
            S_DEC: begin
                case (opc)
                    OP_LOAD, OP_STORE, OP_ADD, OP_SUBT,
                    OP_ADDI, OP_JUMPI: r_d.state = S_MAR;
                    OP_JNS:            r_d.state = S_J1;
                    OP_INPUT:          r_d.state = S_INW;
                    default:           r_d.state = S_EXEC;
                endcase
            end
            S_MAR: begin
                r_d.mar   = x_addr;
                r_d.state = (opc == OP_STORE) ? S_STM : S_RD;
            end
            S_RD: begin
                r_d.mbr   = mem_rdata;
                r_d.state = (opc == OP_ADDI) ? S_PTR : S_EXEC;
            end
            S_PTR: begin
                r_d.mar   = r_q.mbr[ADDR_W-1:0];
                r_d.state = S_RD2;
            end
            S_RD2: begin
                r_d.mbr   = mem_rdata;
                r_d.state = S_EXEC;
            end
            S_STM: begin
                r_d.mbr   = r_q.ac;
                r_d.state = S_STW;
            end
            S_STW: r_d.state = S_FMAR;
            S_INW: begin
                if (in_valid) begin
                    r_d.inreg = in_data;
                    r_d.state = S_EXEC;
                end
            end
            S_J1: begin
                r_d.mbr   = {{(WORD_W-ADDR_W){1'b0}}, r_q.pc};
                r_d.state = S_J2;
            end
            S_J2: begin
                r_d.mar   = x_addr;
                r_d.state = S_J3;
            end
            S_J3: r_d.state = S_J4;
            S_J4: begin
                r_d.mbr   = {{(WORD_W-ADDR_W){1'b0}}, x_addr};
                r_d.state = S_J5;
            end
            S_J5: begin
                r_d.ac    = AC_ONE;
                r_d.state = S_J6;
            end
            S_J6: begin
                r_d.ac    = alu_y;
                r_d.state = S_J7;
            end
            S_J7: begin
                r_d.pc    = r_q.ac[ADDR_W-1:0];
                r_d.state = S_FMAR;
            end
            S_EXEC: begin
                r_d.state = S_FMAR;
                case (opc)
                    OP_LOAD:          r_d.ac = r_q.mbr;
                    OP_ADD, OP_ADDI,
                    OP_SUBT:          r_d.ac = alu_y;
                    OP_INPUT:         r_d.ac = {{(WORD_W-IO_W){1'b0}}, r_q.inreg};
                    OP_OUTPUT: begin
                        r_d.outreg = r_q.ac[IO_W-1:0];
                        r_d.out_we = 1'b1;
                    end
                    OP_HALT: begin
                        r_d.halted = 1'b1;
                        r_d.state  = S_HALT;
                    end
                    OP_SKIP:          if (skip_take) r_d.pc = r_q.pc + PC_ONE;
                    OP_JUMP:          r_d.pc = x_addr;
                    OP_CLEAR:         r_d.ac = '0;
                    OP_JUMPI:         r_d.pc = r_q.mbr[ADDR_W-1:0];
                    default:          r_d.ac = r_q.ac;
                endcase
            end
            S_HALT:  r_d.state = S_HALT;
            default: r_d.state = S_FMAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data = r_q.outreg;
    assign out_we   = r_q.out_we;
    assign halted   = r_q.halted;

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_FMAR) |=> (r_q.state == S_FIR)); // R1
    AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_FIR) |-> (r_q.mar == r_q.pc)); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_FPC) |=> (r_q.pc == $past(r_q.pc) + PC_ONE)); // R1
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (r_q.state != S_FIR) |=> $stable(r_q.ir)); // R1
    AST_INPUT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_INW && !in_valid) |=> (r_q.state == S_INW)); // R9
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_we |=> !out_we); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R11
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!out_we && !mem_we)); // R11

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [11:0] prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  out_data;
    logic        out_we;
    logic        halted;

    int errs = 0;
    int checks = 0;
    logic [7:0] cap [16];
    int ncap;
    int first_cyc;

    always #4 clk = ~clk;

    acc_core dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_we(out_we), .halted(halted)
    );

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
        $finish;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
        return {op, a};
    endfunction

    function automatic bit exp_skip(logic [1:0] cc, logic [15:0] v);
        case (cc)
            2'b00:   return v[15];
            2'b01:   return v == 16'h0;
            2'b10:   return !v[15] && v != 16'h0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic poke(logic [11:0] a, logic [15:0] d);
        prog_addr  = a;
        prog_wdata = d;
        prog_we    = 1'b1;
        @(negedge clk);
        prog_we    = 1'b0;
    endtask

    task automatic enter_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic start();
        rst       = 1'b0;
        ncap      = 0;
        first_cyc = -1;
    endtask

    task automatic run_to_halt(string req);
        bool_loop: for (int c = 1; c <= 3000; c++) begin
            @(negedge clk);
            if (out_we) begin
                if (first_cyc < 0) first_cyc = c;
                if (ncap < 16) cap[ncap] = out_data;
                ncap++;
            end
            if (halted) break;
        end
        chk({req, " halted"}, int'(halted), 1);
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (out_we) extra++;
            end
            chk("R11 no output after halt", extra, 0);
            chk("R11 halt sticky", int'(halted), 1);
        end
    endtask

    initial begin
        void'($urandom(32'h0000C0DE));

        // reset state, first-output timing (R1, R10)
        enter_reset();
        @(negedge clk);
        chk("R1 reset halted", int'(halted), 0);
        chk("R1 reset out_we", int'(out_we), 0);
        chk("R1 reset out_data", int'(out_data), 0);
        poke(12'h000, ins(4'h6, 12'h000));
        poke(12'h001, ins(4'h7, 12'h000));
        start();
        run_to_halt("R1");
        chk("R1 fetch latency", first_cyc, 5);
        chk("R10 output count", ncap, 1);
        chk("R1 AC reset zero", int'(cap[0]), 0);

        // load, store, add, subtract with random operands (R2, R3)
        for (int it = 0; it < 16; it++) begin
            logic [15:0] a, b, s, d;
            a = 16'($urandom);
            b = 16'($urandom);
            if (it == 0) begin a = 16'h7FFF; b = 16'h0001; end
            if (it == 1) begin a = 16'h0000; b = 16'hFFFF; end
            s = a + b;
            d = a - b;
            enter_reset();
            poke(12'h000, ins(4'h1, 12'h100));
            poke(12'h001, ins(4'h3, 12'h101));
            poke(12'h002, ins(4'h6, 12'h000));
            poke(12'h003, ins(4'h2, 12'h102));
            poke(12'h004, ins(4'h1, 12'h100));
            poke(12'h005, ins(4'h4, 12'h101));
            poke(12'h006, ins(4'h6, 12'h000));
            poke(12'h007, ins(4'h1, 12'h102));
            poke(12'h008, ins(4'h6, 12'h000));
            poke(12'h009, ins(4'h7, 12'h000));
            poke(12'h100, a);
            poke(12'h101, b);
            poke(12'h102, 16'h0000);
            start();
            run_to_halt("R2");
            chk("R10 output count arith", ncap, 3);
            chk("R3 add", int'(cap[0]), int'(s[7:0]));
            chk("R3 subtract", int'(cap[1]), int'(d[7:0]));
            chk("R2 store then load", int'(cap[2]), int'(s[7:0]));
        end

        // conditional skip over all condition codes (R5)
        for (int it = 0; it < 28; it++) begin
            logic [15:0] v;
            logic [1:0]  cc;
            case (it % 7)
                0: v = 16'h8000;
                1: v = 16'hFFFF;
                2: v = 16'h0000;
                3: v = 16'h0001;
                4: v = 16'h7FFF;
                default: v = 16'($urandom);
            endcase
            cc = 2'(it / 7);
            enter_reset();
            poke(12'h000, ins(4'h1, 12'h100));
            poke(12'h001, ins(4'h8, {cc, 10'h000}));
            poke(12'h002, ins(4'h6, 12'h000));
            poke(12'h003, ins(4'h7, 12'h000));
            poke(12'h100, v);
            start();
            run_to_halt("R5");
            chk($sformatf("R5 skip cc=%0d v=%h", cc, v), ncap, exp_skip(cc, v) ? 0 : 1);
        end

        // clear, indirect add, direct and indirect jumps (R4, R6, R8)
        for (int it = 0; it < 4; it++) begin
            logic [15:0] a, b, s;
            a = 16'($urandom) | 16'h0001;
            b = 16'($urandom);
            s = a + b;
            enter_reset();
            poke(12'h000, ins(4'h1, 12'h100));
            poke(12'h001, ins(4'hA, 12'h000));
            poke(12'h002, ins(4'h6, 12'h000));
            poke(12'h003, ins(4'h1, 12'h100));
            poke(12'h004, ins(4'hB, 12'h101));
            poke(12'h005, ins(4'h6, 12'h000));
            poke(12'h006, ins(4'h9, 12'h008));
            poke(12'h007, ins(4'h6, 12'h000));
            poke(12'h008, ins(4'hC, 12'h103));
            poke(12'h009, ins(4'h6, 12'h000));
            poke(12'h00A, ins(4'h6, 12'h000));
            poke(12'h00B, ins(4'h7, 12'h000));
            poke(12'h100, a);
            poke(12'h101, 16'hF105);
            poke(12'h103, 16'h000A);
            poke(12'h105, b);
            poke(12'h005 + 12'h100, b);
            start();
            run_to_halt("R6");
            chk("R6 jumps skip outputs", ncap, 3);
            chk("R8 clear", int'(cap[0]), 0);
            chk("R4 indirect add", int'(cap[1]), int'(s[7:0]));
            chk("R6 landing output", int'(cap[2]), int'(s[7:0]));
        end

        // jump-and-store linkage (R7)
        enter_reset();
        poke(12'h000, ins(4'h1, 12'h100));
        poke(12'h001, ins(4'h0, 12'h234));
        poke(12'h002, ins(4'h6, 12'h000));
        poke(12'h003, ins(4'h7, 12'h000));
        poke(12'h235, ins(4'h6, 12'h000));
        poke(12'h236, ins(4'h1, 12'h234));
        poke(12'h237, ins(4'h6, 12'h000));
        poke(12'h238, ins(4'hC, 12'h234));
        poke(12'h100, 16'h0055);
        start();
        run_to_halt("R7");
        chk("R7 output count", ncap, 3);
        chk("R7 AC holds X+1", int'(cap[0]), 8'h35);
        chk("R7 return address stored", int'(cap[1]), 8'h02);
        chk("R7 return lands after call", int'(cap[2]), 8'h02);

        // input wait, zero extension, no-op opcodes, dropped loader write (R9, R12, R13)
        enter_reset();
        poke(12'h000, ins(4'h5, 12'h000));
        poke(12'h001, ins(4'h6, 12'h000));
        poke(12'h002, ins(4'h8, 12'h800));
        poke(12'h003, ins(4'h7, 12'h000));
        poke(12'h004, ins(4'hD, 12'h123));
        poke(12'h005, ins(4'hE, 12'h020));
        poke(12'h006, ins(4'hF, 12'hFFF));
        poke(12'h007, ins(4'h1, 12'h020));
        poke(12'h008, ins(4'h6, 12'h000));
        poke(12'h009, ins(4'h7, 12'h000));
        poke(12'h020, 16'h0042);
        start();
        begin
            int early = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (out_we || halted) early++;
                if (k == 20) begin
                    prog_addr  = 12'h020;
                    prog_wdata = 16'h0099;
                    prog_we    = 1'b1;
                end
                if (k == 21) prog_we = 1'b0;
            end
            chk("R9 waits for valid", early, 0);
        end
        in_data  = 8'hA5;
        in_valid = 1'b1;
        run_to_halt("R9");
        in_valid = 1'b0;
        chk("R9 zero-extended input skips on positive", ncap, 2);
        chk("R9 input value", int'(cap[0]), 8'hA5);
        chk("R13 loader write ignored while running", int'(cap[1]), 8'h42);
        chk("R12 no-op opcodes keep AC", int'(cap[1]), 8'h42);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule